// File: doc/BRIEF.md
# Coded Reference Frequency Divider

This block takes a crystal reference clock and divides it down to the phase-comparison rate used by a frequency synthesizer's phase detector. The division ratio is not given as a count. A 5-bit selection code names a base factor (1, 5, 6 or 7) and a power-of-two multiplier. Together they give 29 legal ratios between 2 and 448. Three code points have no ratio and are rejected.

Each division period produces one output pulse, one reference clock wide. When the code changes, the new ratio is taken up only at the boundary of the period already running, so no period is ever cut short. An illegal code raises a flag, and the divider keeps running at the last legal ratio it accepted. A 3-bit test selector can route the comparison pulse to a test pin for observation. Any other selector value holds that pin low.

Reset is asynchronous and active low, and its release is synchronised inside the block. The first comparison pulse follows on the first clock edge after the internal reset lifts.

Top module: `ref_ratio_divider`

## Requirements
- R1: Codes with the two top bits 00 (values 0 to 7) divide by 2 raised to (low three bits + 1): 2, 4, 8 up to 256.
- R2: Codes 01 followed by low bits 1 to 7 divide by 5 times 2 raised to (low bits - 1): 5 up to 320.
- R3: Codes 10 followed by low bits 1 to 7 divide by 6 times 2 raised to (low bits - 1): 6 up to 384.
- R4: Codes 11 followed by low bits 1 to 7 divide by 7 times 2 raised to (low bits - 1): 7 up to 448.
- R5: Codes 01000, 10000 and 11000 are illegal. `code_bad` is high one clock after such a code is present and low one clock after a legal code is present. While an illegal code is applied, the ratio stays at the last legal ratio.
- R6: When `test_sel` is 101, 110 or 111, `tport` equals `fcomp` in every cycle.
- R7: For every other `test_sel` value, `tport` is low.
- R8: A ratio change takes effect only at the next terminal count. The period already running keeps its old length, and when the code changes more than once within one period, only the value present at the boundary is used.
- R9: `fcomp` is high for exactly one clock per period. The spacing between rising pulses equals the ratio in effect.
- R10: While reset is asserted, `fcomp`, `code_bad` and `tport` are low. The reset ratio is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock to be divided |
| arst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 5 | Ratio selection code: group in bits 4:3, exponent in bits 2:0 |
| test_sel | input | 3 | Test selector; 101, 110 and 111 route the comparison pulse to `tport` |
| fcomp | output | 1 | Comparison pulse, one clock wide per period |
| code_bad | output | 1 | High while the last sampled code was illegal |
| tport | output | 1 | Test pin carrying `fcomp` when routed, else low |

## Verification
Two functions can fall in the same cycle: sampling a new code and reloading the counter at the terminal count. The bench provokes this by changing the code on the very cycle a comparison pulse is seen. It expects the period already loaded to keep its old length, and only the one after it to follow the new code. It also changes the code twice inside one long period and checks that only the second value appears. An illegal code applied at a boundary must raise the flag while the pulse spacing stays at the previous legal ratio.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CODE_W  = 5;
  localparam int GRP_W   = 2;
  localparam int EXP_W   = CODE_W - GRP_W;
  localparam int TSEL_W  = 3;
  localparam int RATIO_W = 9;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic   legal;
    ratio_t ratio;
  } decode_t;

  localparam ratio_t RESET_RATIO = ratio_t'(2);
endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
  import refdiv_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output decode_t           dec
);
  logic [GRP_W-1:0] grp;
  logic [EXP_W-1:0] expo;
  ratio_t           base;
  logic [EXP_W-1:0] shamt;

  assign grp  = code[CODE_W-1:EXP_W];
  assign expo = code[EXP_W-1:0];

  always_comb begin
    base  = ratio_t'(2);
    shamt = expo;
    dec.legal = 1'b1;
    unique case (grp)
      2'd0: begin
        base  = ratio_t'(2);
        shamt = expo;
      end
      default: begin
        base  = ratio_t'(grp) + ratio_t'(4);
        shamt = expo - EXP_W'(1);
        dec.legal = (expo != '0);
      end
    endcase
    dec.ratio = dec.legal ? (base << shamt) : '0;
  end
endmodule

// File: rtl/refdiv_ratio_hold.sv
module refdiv_ratio_hold
  import refdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  decode_t dec,
  output ratio_t  held_ratio,
  output logic    bad_q
);
  ratio_t ratio_q, ratio_d;
  logic   ratio_en;
  logic   bad_d;

  assign ratio_en = dec.legal;

  always_comb begin
    ratio_d = ratio_q;
    if (ratio_en) ratio_d = dec.ratio;
    bad_d = ~dec.legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RESET_RATIO;
      bad_q   <= 1'b0;
    end else begin
      ratio_q <= ratio_d;
      bad_q   <= bad_d;
    end
  end

  assign held_ratio = ratio_q;
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t reload_ratio,
  output logic   pulse_q
);
  ratio_t cnt_q, cnt_d;
  logic   terminal;
  logic   pulse_d;

  assign terminal = (cnt_q == '0);

  always_comb begin
    if (terminal) cnt_d = reload_ratio - ratio_t'(1);
    else          cnt_d = cnt_q - ratio_t'(1);
    pulse_d = terminal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end
endmodule

// File: rtl/refdiv_tport.sv
module refdiv_tport
  import refdiv_pkg::*;
(
  input  logic [TSEL_W-1:0] sel,
  input  logic              pulse,
  output logic              pin
);
  logic route;

  assign route = sel[TSEL_W-1] & (|sel[TSEL_W-2:0]);
  assign pin   = route & pulse;
endmodule

// File: rtl/refdiv_rst_sync.sv
module refdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ref_ratio_divider.sv
module ref_ratio_divider
  import refdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              arst_n,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic [TSEL_W-1:0] test_sel,
  output logic              fcomp,
  output logic              code_bad,
  output logic              tport
);
  logic    rst_n_int;
  decode_t dec;
  ratio_t  held_ratio;

  refdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk_ref),
    .arst_n (arst_n),
    .rst_n  (rst_n_int)
  );

  refdiv_decode u_dec (
    .code (ratio_code),
    .dec  (dec)
  );

  refdiv_ratio_hold u_hold (
    .clk        (clk_ref),
    .rst_n      (rst_n_int),
    .dec        (dec),
    .held_ratio (held_ratio),
    .bad_q      (code_bad)
  );

  refdiv_counter u_cnt (
    .clk          (clk_ref),
    .rst_n        (rst_n_int),
    .reload_ratio (held_ratio),
    .pulse_q      (fcomp)
  );

  refdiv_tport u_tp (
    .sel   (test_sel),
    .pulse (fcomp),
    .pin   (tport)
  );
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
  import refdiv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code,
  input logic [TSEL_W-1:0] sel,
  input logic              fcomp,
  input logic              bad,
  input logic              tport,
  input ratio_t            held
);
  logic code_illegal;
  logic routed;

  assign code_illegal = (code[EXP_W-1:0] == '0) && (code[CODE_W-1:EXP_W] != '0);
  assign routed = (sel == 3'b101) || (sel == 3'b110) || (sel == 3'b111);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fcomp |=> !fcomp); // R9

  AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    code_illegal |=> bad); // R5

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !code_illegal |=> !bad); // R5

  AST_RATIO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> $stable(held)); // R5

  AST_TPORT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    routed |-> (tport == fcomp)); // R6

  AST_TPORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !routed |-> !tport); // R7
endmodule

bind ref_ratio_divider refdiv_checker u_chk (
  .clk   (clk_ref),
  .rst_n (rst_n_int),
  .code  (ratio_code),
  .sel   (test_sel),
  .fcomp (fcomp),
  .bad   (code_bad),
  .tport (tport),
  .held  (held_ratio)
);

// File: tb/sim_ref_ratio_divider.sv
`timescale 1ns/1ps
module sim_ref_ratio_divider;
  logic       clk;
  logic       arst_n;
  logic [4:0] ratio_code;
  logic [2:0] test_sel;
  logic       fcomp, code_bad, tport;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  string tag_q[$];
  int cur;
  bit armed = 0;
  bit started = 0;

  ref_ratio_divider u0 (
    .clk_ref(clk), .arst_n(arst_n), .ratio_code(ratio_code),
    .test_sel(test_sel), .fcomp(fcomp), .code_bad(code_bad), .tport(tport)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic bit is_bad(input logic [4:0] c);
    return (c[4:3] != 2'b00) && (c[2:0] == 3'b000);
  endfunction

  // expected ratio from the requirement text: base factor times power of two
  function automatic int ratio_of(input logic [4:0] c);
    int mult;
    int base;
    if (c[4:3] == 2'b00) begin
      base = 1; mult = 1 << (int'(c[2:0]) + 1);
    end else begin
      base = 4 + int'(c[4:3]); mult = 1 << (int'(c[2:0]) - 1);
    end
    return base * mult;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int gap, input string tag);
    exp_q.push_back(gap);
    tag_q.push_back(tag);
  endtask

  task automatic wait_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!fcomp);
    end
  endtask

  // called at a pulse negedge; ends at a pulse negedge
  task automatic run(input logic [4:0] c, input int n, input string tag);
    int nn;
    nn = is_bad(c) ? cur : ratio_of(c);
    ratio_code = c;
    push(cur, "R8");
    for (int i = 1; i < n; i++) push(nn, tag);
    wait_pulses(n);
    cur = nn;
    check(code_bad == is_bad(c), "R5 flag", int'(code_bad), int'(is_bad(c)));
  endtask

  // two code changes inside one period: only the later one counts (R8)
  task automatic run_change(input logic [4:0] a, input logic [4:0] b, input int n);
    int nb;
    nb = ratio_of(b);
    ratio_code = a;
    push(cur, "R8");
    repeat (3) @(negedge clk);
    ratio_code = b;
    for (int i = 1; i < n; i++) push(nb, "R8 last code wins");
    wait_pulses(n);
    cur = nb;
  endtask

  // monitor: measures pulse spacing and test pin
  initial begin
    int cyc;
    bit prev;
    int e;
    string t;
    cyc = 0; prev = 0;
    forever begin
      @(negedge clk); #1;
      if (armed) begin
        cyc++;
        check(!(fcomp && prev), "R9 pulse width", int'(fcomp), 0);
        if (fcomp) begin
          if (started) begin
            if (exp_q.size() == 0) check(0, "R9 unexpected pulse", cyc, 0);
            else begin
              e = exp_q.pop_front(); t = tag_q.pop_front();
              check(cyc == e, t, cyc, e);
            end
          end
          started = 1;
          cyc = 0;
        end
        if (test_sel inside {3'b101, 3'b110, 3'b111})
          check(tport == fcomp, "R6 tport copy", int'(tport), int'(fcomp));
        else
          check(tport == 1'b0, "R7 tport quiet", int'(tport), 0);
        prev = fcomp;
      end
    end
  end

  initial begin
    bit timed_out;
    timed_out = 0;
    arst_n = 0; ratio_code = 5'b00000; test_sel = 3'b000;
    repeat (4) @(negedge clk);
    check(fcomp == 0, "R10 reset fcomp", int'(fcomp), 0);
    check(code_bad == 0, "R10 reset flag", int'(code_bad), 0);
    check(tport == 0, "R10 reset tport", int'(tport), 0);
    fork
      begin
        arst_n = 1;
        armed = 1;
        cur = 2;
        wait_pulses(1);
        push(2, "R10 reset ratio");
        wait_pulses(1);
        run(5'b00000, 3, "R1");
        run(5'b00111, 2, "R1");
        test_sel = 3'b101;
        run(5'b01001, 3, "R2");
        run(5'b01111, 2, "R2");
        test_sel = 3'b100;
        run(5'b10001, 3, "R3");
        run(5'b10111, 2, "R3");
        test_sel = 3'b110;
        run(5'b11001, 3, "R4");
        run(5'b11111, 2, "R4");
        run(5'b01000, 2, "R5 hold");
        run(5'b00011, 3, "R1");
        run(5'b10000, 2, "R5 hold");
        test_sel = 3'b011;
        run(5'b11000, 2, "R5 hold");
        run(5'b00001, 3, "R1");
        test_sel = 3'b111;
        run(5'b01001, 2, "R2");
        run_change(5'b00111, 5'b10001, 3);
        run(5'b11010, 3, "R4");
        test_sel = 3'b001;
        run(5'b01011, 2, "R2");
        run(5'b10010, 2, "R3");
        wait_pulses(1);
        check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) check(0, "watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule